// File: doc/BRIEF.md
# Eight-Phase DDA Bilinear Upscaler

This block enlarges a video image by producing output pixels that lie between the pixels of a source grid. Two digital differential analyzer (DDA) steppers, one per axis, walk fixed-point positions across the source. The horizontal stepper moves once per output point and the vertical stepper once per line. The top three bits of each fractional position select one of eight sub-pixel phases. For every output point the source presents the four surrounding samples: top-left, top-right, bottom-left and bottom-right. The block then blends them with a 2-tap filter along each axis. The weights are multiples of one eighth.

The steppers tell the source when to move on. The horizontal advance flag means the next point needs the next source column pair. The vertical advance flag, raised at a line start, means the line pair must move down one row. Each pixel carries several independent colour components. Each component goes through the same arithmetic, and the result appears two clock cycles after the point is presented.

Top module: `dda_bilinear_upscaler`

## Requirements
- R1: A point presented with `inValid` high in one cycle gives `outValid` high exactly two clock edges later. Cycles without `inValid` give `outValid` low two edges later.
- R2: Take horizontal phase x and vertical phase y, each 0..7, and samples p00 (top-left), p10 (top-right), p01 (bottom-left) and p11 (bottom-right). Each output component equals ((p00·(8−x) + p10·x)·(8−y) + (p01·(8−x) + p11·x)·y + 32) / 64, truncated. With x = y = 0 the output equals p00.
- R3: The horizontal position is a 16-bit fraction. Each valid point uses bits 15:13 of the current position as x, and the clamped horizontal step is then added. `hAdvance` is high, combinationally in that cycle, exactly when the addition carries out of bit 15.
- R4: `lineStart` zeroes the horizontal position before use, so a point presented in the same cycle uses x = 0. It acts even when `inValid` is low.
- R5: `frameStart` sets the vertical position to zero. A `lineStart` without `frameStart` adds the clamped vertical step, and `vAdvance` is high in that cycle exactly when this addition carries. All points of a line use bits 15:13 of the vertical position as y.
- R6: A step below 8192 is treated as 8192, which limits enlargement to 8x. A step above 65536 is treated as 65536.
- R7: A step of 65536 gives 1:1 pass-through: the phase stays 0 and every valid point (or every line, for the vertical axis) raises its advance flag.
- R8: During and right after reset, `outValid` is low and both positions are zero.
- R9: Components are packed in 8-bit lanes, with lane k in bits 8k+7:8k of every sample and of `outPix`. Each lane is computed independently with the shared phases.
- R10: Full-scale samples (255) give 255 at every phase pair, with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Start of frame, clears vertical position |
| lineStart | input | 1 | Start of line, clears horizontal position and steps vertical |
| inValid | input | 1 | The four samples form a point to be computed this cycle |
| hStep | input | 17 | Horizontal step, 65536 / scale factor |
| vStep | input | 17 | Vertical step, 65536 / scale factor |
| a00 | input | 24 | Top-left sample, three 8-bit lanes |
| a10 | input | 24 | Top-right sample |
| a01 | input | 24 | Bottom-left sample |
| a11 | input | 24 | Bottom-right sample |
| outValid | output | 1 | `outPix` holds a computed point |
| outPix | output | 24 | Interpolated components |
| hAdvance | output | 1 | Source moves to the next column pair after this point |
| vAdvance | output | 1 | Source moves to the next row pair at this line start |

## Verification
Unity steps with random samples must return the top-left sample unchanged. This separates a correct weight of 8 from an off-by-one weight. A 0-to-255 ramp at step 8192 sweeps all eight horizontal phases, so each weight and the rounding constant show up in a distinct output value. Full-scale samples at random phases expose any wrap in the 14-bit sum. Out-of-range steps and mid-line restarts tell the clamp and the position reset apart from plain stepping. A long random run mixes frame and line strobes with idle cycles. It checks the advance flags and the phases across many carries, with distinct values per lane.

// File: rtl/upscale_pkg.sv
package upscale_pkg;
  localparam int PHASE_W = 3;

  typedef struct packed {
    logic               valid;
    logic [PHASE_W-1:0] hPhase;
    logic [PHASE_W-1:0] vPhase;
  } stepStrobe_t;
endpackage

// File: rtl/upscale_dda_ctrl.sv
module upscale_dda_ctrl
  import upscale_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frameStart,
  input  logic             lineStart,
  input  logic             inValid,
  input  logic [ACC_W:0]   hStep,
  input  logic [ACC_W:0]   vStep,
  output stepStrobe_t      strobe,
  output logic             hAdvance,
  output logic             vAdvance
);
  localparam int STEP_W = ACC_W + 1;
  localparam logic [STEP_W-1:0] MIN_STEP = STEP_W'(1) << (ACC_W - PHASE_W);
  localparam logic [STEP_W-1:0] MAX_STEP = STEP_W'(1) << ACC_W;

  function automatic logic [STEP_W-1:0] clampStep(input logic [STEP_W-1:0] s);
    if (s < MIN_STEP) return MIN_STEP;
    if (s > MAX_STEP) return MAX_STEP;
    return s;
  endfunction

  logic [ACC_W-1:0]  hAcc, vAcc, hEff, vEff, hNext;
  logic [STEP_W-1:0] hSum, vSum;

  // horizontal: restart at line start, step once per valid point
  always_comb begin
    hEff     = lineStart ? '0 : hAcc;
    hSum     = {1'b0, hEff} + clampStep(hStep);
    hNext    = inValid ? hSum[ACC_W-1:0] : hEff;
    hAdvance = inValid & hSum[ACC_W];
  end

  // vertical: restart at frame start, step once per line start
  always_comb begin
    vSum = {1'b0, vAcc} + clampStep(vStep);
    if (frameStart) begin
      vEff     = '0;
      vAdvance = 1'b0;
    end else if (lineStart) begin
      vEff     = vSum[ACC_W-1:0];
      vAdvance = vSum[ACC_W];
    end else begin
      vEff     = vAcc;
      vAdvance = 1'b0;
    end
  end

  always_comb begin
    strobe.valid  = inValid;
    strobe.hPhase = hEff[ACC_W-1 -: PHASE_W];
    strobe.vPhase = vEff[ACC_W-1 -: PHASE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hAcc <= '0;
      vAcc <= '0;
    end else begin
      hAcc <= hNext;
      vAcc <= vEff;
    end
  end

  assert_line_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lineStart && !inValid) |=> (hAcc == '0));

  assert_frame_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |=> (vAcc == '0));

  assert_adv_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hAdvance |-> inValid);

  assert_unity_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && hStep == MAX_STEP) |-> hAdvance);

  assert_min_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !lineStart && hStep <= MIN_STEP) |=>
      (ACC_W'(hAcc - $past(hAcc)) == MIN_STEP[ACC_W-1:0]));
endmodule

// File: rtl/upscale_interp.sv
module upscale_interp
  import upscale_pkg::*;
#(
  parameter int COMP_W   = 8,
  parameter int NUM_COMP = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  stepStrobe_t                strobe,
  input  logic [NUM_COMP*COMP_W-1:0] a00,
  input  logic [NUM_COMP*COMP_W-1:0] a10,
  input  logic [NUM_COMP*COMP_W-1:0] a01,
  input  logic [NUM_COMP*COMP_W-1:0] a11,
  output logic                       outValid,
  output logic [NUM_COMP*COMP_W-1:0] outPix
);
  localparam int PIX_W = NUM_COMP * COMP_W;
  localparam int WT_W  = PHASE_W + 1;
  localparam int B_W   = COMP_W + PHASE_W + 1;
  localparam int Z_W   = COMP_W + 2 * PHASE_W + 1;
  localparam logic [WT_W-1:0] ONE   = WT_W'(1) << PHASE_W;
  localparam logic [Z_W-1:0]  ROUND = Z_W'(1) << (2 * PHASE_W - 1);

  logic [WT_W-1:0] wx, wxInv, wy, wyInv;
  logic [PHASE_W-1:0] s1VPhase;
  logic s1Valid;
  logic [NUM_COMP-1:0][B_W-1:0] b1All, b2All, s1B1, s1B2;
  logic [NUM_COMP-1:0][COMP_W-1:0] zAll;

  always_comb begin
    wx    = {1'b0, strobe.hPhase};
    wxInv = ONE - wx;
    wy    = {1'b0, s1VPhase};
    wyInv = ONE - wy;
  end

  for (genvar k = 0; k < NUM_COMP; k++) begin : gLane
    logic [COMP_W-1:0] p00, p10, p01, p11;
    logic [Z_W-1:0]    zSum;
    always_comb begin
      p00 = a00[k*COMP_W +: COMP_W];
      p10 = a10[k*COMP_W +: COMP_W];
      p01 = a01[k*COMP_W +: COMP_W];
      p11 = a11[k*COMP_W +: COMP_W];
      b1All[k] = B_W'(p00) * B_W'(wxInv) + B_W'(p10) * B_W'(wx);
      b2All[k] = B_W'(p01) * B_W'(wxInv) + B_W'(p11) * B_W'(wx);
      zSum     = Z_W'(s1B1[k]) * Z_W'(wyInv) + Z_W'(s1B2[k]) * Z_W'(wy) + ROUND;
      zAll[k]  = zSum[2*PHASE_W +: COMP_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1Valid  <= 1'b0;
      s1VPhase <= '0;
      s1B1     <= '0;
      s1B2     <= '0;
      outValid <= 1'b0;
      outPix   <= '0;
    end else begin
      s1Valid  <= strobe.valid;
      s1VPhase <= strobe.vPhase;
      s1B1     <= b1All;
      s1B2     <= b2All;
      outValid <= s1Valid;
      outPix   <= PIX_W'(zAll);
    end
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.valid |=> ##1 outValid);

  assert_idle_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.valid |=> ##1 !outValid);

  assert_corner_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.valid && strobe.hPhase == '0 && strobe.vPhase == '0) |=> ##1
      (outPix == $past(a00, 2)));
endmodule

// File: rtl/dda_bilinear_upscaler.sv
module dda_bilinear_upscaler
  import upscale_pkg::*;
#(
  parameter int ACC_W    = 16,
  parameter int COMP_W   = 8,
  parameter int NUM_COMP = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frameStart,
  input  logic                       lineStart,
  input  logic                       inValid,
  input  logic [ACC_W:0]             hStep,
  input  logic [ACC_W:0]             vStep,
  input  logic [NUM_COMP*COMP_W-1:0] a00,
  input  logic [NUM_COMP*COMP_W-1:0] a10,
  input  logic [NUM_COMP*COMP_W-1:0] a01,
  input  logic [NUM_COMP*COMP_W-1:0] a11,
  output logic                       outValid,
  output logic [NUM_COMP*COMP_W-1:0] outPix,
  output logic                       hAdvance,
  output logic                       vAdvance
);
  stepStrobe_t strobe;

  upscale_dda_ctrl #(.ACC_W(ACC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart), .lineStart(lineStart),
    .inValid(inValid), .hStep(hStep), .vStep(vStep), .strobe(strobe),
    .hAdvance(hAdvance), .vAdvance(vAdvance)
  );

  upscale_interp #(.COMP_W(COMP_W), .NUM_COMP(NUM_COMP)) u_interp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .a00(a00), .a10(a10),
    .a01(a01), .a11(a11), .outValid(outValid), .outPix(outPix)
  );
endmodule

// File: tb/dda_bilinear_upscaler_tb.sv
`timescale 1ns/1ps
module dda_bilinear_upscaler_tb;
  localparam int COMP_W = 8;
  localparam int NUM_COMP = 3;
  localparam int PW = COMP_W * NUM_COMP;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frameStart = 0, lineStart = 0, inValid = 0;
  logic [16:0] hStep = 17'd65536, vStep = 17'd65536;
  logic [PW-1:0] a00 = '0, a10 = '0, a01 = '0, a11 = '0;
  logic outValid, hAdvance, vAdvance;
  logic [PW-1:0] outPix;

  always #2 clk = ~clk;

  dda_bilinear_upscaler u_dut (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart), .lineStart(lineStart),
    .inValid(inValid), .hStep(hStep), .vStep(vStep), .a00(a00), .a10(a10),
    .a01(a01), .a11(a11), .outValid(outValid), .outPix(outPix),
    .hAdvance(hAdvance), .vAdvance(vAdvance)
  );

  int vecs = 0, errs = 0;
  int hAccM = 0, vAccM = 0;
  bit pv1 = 0, pv2 = 0;
  logic [PW-1:0] pp1, pp2;
  string tag1 = "R2", tag2 = "R2";
  bit done = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int clampS(int s);
    if (s < 8192) return 8192;
    if (s > 65536) return 65536;
    return s;
  endfunction

  function automatic int lerp(int p00, int p10, int p01, int p11, int x, int y);
    int b1 = p00 * (8 - x) + p10 * x;
    int b2 = p01 * (8 - x) + p11 * x;
    return (b1 * (8 - y) + b2 * y + 32) / 64;
  endfunction

  task automatic randSamples();
    a00 = PW'($urandom); a10 = PW'($urandom);
    a01 = PW'($urandom); a11 = PW'($urandom);
  endtask

  // called at a falling edge: checks the point from two cycles back, drives a new one
  task automatic step(bit fs, bit ls, bit v, int hs, int vs, string tag);
    int hEff, vEff, hSum, vSum, x, y;
    bit expH, expV;
    logic [PW-1:0] e;
    chk("R1", 64'(outValid), 64'(pv2));
    if (pv2) chk(tag2, 64'(outPix), 64'(pp2));
    frameStart = fs; lineStart = ls; inValid = v;
    hStep = 17'(hs); vStep = 17'(vs);
    hEff = ls ? 0 : hAccM;
    hSum = hEff + clampS(hs);
    expH = v && (hSum > 65535);
    vSum = vAccM + clampS(vs);
    expV = 0;
    if (fs) vEff = 0;
    else if (ls) begin vEff = vSum & 32'hFFFF; expV = (vSum > 65535); end
    else vEff = vAccM;
    x = hEff >> 13; y = vEff >> 13;
    for (int k = 0; k < NUM_COMP; k++)
      e[k*COMP_W +: COMP_W] = COMP_W'(lerp(int'(a00[k*COMP_W +: COMP_W]),
        int'(a10[k*COMP_W +: COMP_W]), int'(a01[k*COMP_W +: COMP_W]),
        int'(a11[k*COMP_W +: COMP_W]), x, y));
    #1;
    chk("R3", 64'(hAdvance), 64'(expH));
    chk("R5", 64'(vAdvance), 64'(expV));
    hAccM = v ? (hSum & 32'hFFFF) : hEff;
    vAccM = vEff;
    pp2 = pp1; pv2 = pv1; tag2 = tag1;
    pp1 = e; pv1 = v; tag1 = tag;
    @(negedge clk);
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      errs++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R8", 64'(outValid), 64'd0);
    chk("R8", 64'(hAdvance), 64'd0);
    rst_n = 1'b1;
    chk("R8", 64'(outValid), 64'd0);

    // R7: unity steps pass top-left sample through
    for (int i = 0; i < 12; i++) begin
      randSamples();
      step(i == 0, i % 4 == 0, 1, 65536, 65536, "R7");
    end

    // R2: ramp sweeps every horizontal phase at 8x
    for (int i = 0; i < 10; i++) begin
      a00 = '0; a10 = {PW{1'b1}}; a01 = {NUM_COMP{8'd100}}; a11 = {NUM_COMP{8'd20}};
      step(i == 0, i == 0, 1, 8192, 8192, "R2");
    end
    for (int i = 0; i < 24; i++) begin
      a00 = '0; a10 = {PW{1'b1}}; a01 = {PW{1'b1}}; a11 = '0;
      step(0, i % 8 == 0, 1, 8192, 8192, "R2");
    end

    // R10: full scale at random phases
    for (int i = 0; i < 40; i++) begin
      a00 = {PW{1'b1}}; a10 = a00; a01 = a00; a11 = a00;
      step(0, i % 7 == 0, 1, 8192 + int'($urandom_range(0, 40000)), 9000, "R10");
    end

    // R6: out-of-range steps are clamped
    for (int i = 0; i < 20; i++) begin
      randSamples();
      step(i == 0, i % 10 == 0, 1, (i < 10) ? 100 : 100000, (i < 10) ? 5 : 90000, "R6");
    end

    // R4: mid-line restart, with and without a point
    for (int i = 0; i < 18; i++) begin
      randSamples();
      step(0, i == 5 || i == 11, i != 11, 21000, 30000, "R4");
    end

    // R5: vertical stepping across lines
    for (int i = 0; i < 30; i++) begin
      randSamples();
      step(i == 0, i % 3 == 0, i % 3 != 2, 30000, 19000, "R5");
    end

    // R9: distinct values per lane
    for (int i = 0; i < 16; i++) begin
      a00 = {8'd10, 8'd200, 8'd0}; a10 = {8'd250, 8'd5, 8'd128};
      a01 = {8'd77, 8'd33, 8'd255}; a11 = {8'd1, 8'd199, 8'd64};
      step(i == 0, i % 5 == 0, 1, 12345, 23456, "R9");
    end

    // random mix
    for (int i = 0; i < 3000; i++) begin
      randSamples();
      step($urandom_range(0, 99) == 0, $urandom_range(0, 15) == 0,
           $urandom_range(0, 3) != 0, int'($urandom_range(0, 70000)),
           int'($urandom_range(0, 70000)), "R2");
    end

    for (int i = 0; i < 4; i++) step(0, 0, 0, 65536, 65536, "R1");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule